// File: doc/BRIEF.md
# Mode-Selectable Registered Bus Transceiver

This block moves a data word between two buses, side A and side B, in two independent directions. Each direction has its own set of four controls: an active-low storage enable, a latch control, a direction clock and an active-low output enable. Through these controls a word can pass straight through, be frozen by a level-sensitive latch, or be captured on a rising edge of the direction clock. Side A is a three-state driver, with a value vector and a per-pin enable vector. Side B is open-drain: a pin can only be pulled low or released, so several agents can share the line as a wired-OR bus behind an external pull-up.

The block runs on one system clock. The direction clock and the latch control are sampled as ordinary inputs on that clock, and a rising direction-clock edge is recognised when two consecutive samples read 0 and then 1. The transparent path is combinational from the input bus to the output pins. Each direction reads its input from the resolved value of the opposite bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both stored words are cleared and every output pin is released (`a_oe` all 0, `b_pull_low` all 0). After `rst_n` rises, output enables take effect only from the second system clock edge onward. A word stored before reset reads as all zeros afterwards.
- R2: When a direction's latch control is 1, its output word equals its input bus value in the same cycle, whatever its storage enable and direction clock are.
- R3: With the storage enable low, the stored word follows the input on every system clock edge at which the latch control is 1. Once the latch control returns to 0, the output holds the word sampled at the last such edge, at either level of the direction clock.
- R4: With the storage enable low and the latch control 0, a rising direction clock edge loads the input word at the system clock edge that first samples the clock high. The word shows at the output from that edge on. The clock staying high or falling loads nothing.
- R5: With the storage enable high, the stored word never changes: direction clock edges are ignored, and a latch-control pulse passes data through but leaves the stored word unchanged.
- R6: An output enable of 1 releases all pins of that direction: `a_oe` all 0 for B-to-A, `b_pull_low` all 0 for A-to-B. Storage keeps working while released, and the stored word appears once the enable returns to 0.
- R7: On side B, bit i of `b_pull_low` is 1 (pin pulled low) exactly when the A-to-B direction is enabled and bit i of its output word is 0. A 1 bit is never driven, so the bus is the AND of all agents' values under the pull-up.
- R8: The two directions are independent: no control of one direction changes the output of the other.
- R9: On side A, when the B-to-A direction is enabled, `a_oe` is all ones and `a_out` carries the B-to-A output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ab_ce_n | input | 1 | A-to-B storage enable, active low |
| ab_le | input | 1 | A-to-B latch control, 1 = transparent |
| ab_clk | input | 1 | A-to-B direction clock (sampled) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A storage enable, active low |
| ba_le | input | 1 | B-to-A latch control, 1 = transparent |
| ba_clk | input | 1 | B-to-A direction clock (sampled) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_in | input | W | Resolved value of the A bus |
| a_out | output | W | Value driven onto the A bus |
| a_oe | output | W | Per-pin drive enable for the A bus |
| b_in | input | W | Resolved value of the B bus |
| b_pull_low | output | W | Per-pin pull-low request for the open-drain B bus |

## Verification
A stored word gone wrong only shows at the pins when its direction is enabled and its latch control is 0. It then appears in the same cycle as a wrong `a_out` or a wrong pull-low pattern. It can stay hidden through any stretch of transparency or release, so the vectors end each mode with a hold or re-enable step that exposes the stored word. A missed or doubled direction-clock edge shows one system cycle after the edge is sampled, and a mistimed latch close shows on the first cycle after the latch control falls. Wired-OR resolution is checked on the resolved B bus, not only on the drive vector.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // control set of one transfer direction
  typedef struct packed {
    logic ce_n;   // storage enable, active low
    logic le;     // latch control, 1 = transparent
    logic dclk;   // direction clock, sampled
    logic oe_n;   // output enable, active low
  } dir_ctl_t;

  // what the storage register does on a system clock edge
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_FOLLOW  = 2'd1,
    ST_CAPTURE = 2'd2
  } store_op_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign run = sh_q[TOP];
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         drive_en
);
  logic         dclk_q;
  logic         dclk_rise;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  store_op_e    op;

  // rising edge of the direction clock, seen over two samples
  assign dclk_rise = ctl.dclk & ~dclk_q;

  always_comb begin
    op = ST_HOLD;
    if (!ctl.ce_n) begin
      if (ctl.le) begin
        op = ST_FOLLOW;
      end else if (dclk_rise) begin
        op = ST_CAPTURE;
      end
    end
  end

  always_comb begin
    case (op)
      ST_FOLLOW:  store_d = d;
      ST_CAPTURE: store_d = d;
      default:    store_d = store_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      store_q <= '0;
    end else begin
      dclk_q  <= ctl.dclk;
      store_q <= store_d;
    end
  end

  // transparent bypass when the latch control is high
  assign q        = ctl.le ? d : store_q;
  assign drive_en = run & ~ctl.oe_n;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_ce_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull_low
);
  logic         run_q;
  dir_ctl_t     ab_ctl;
  dir_ctl_t     ba_ctl;
  logic [W-1:0] ab_word;
  logic [W-1:0] ba_word;
  logic         ab_en;
  logic         ba_en;

  assign ab_ctl = '{ce_n: ab_ce_n, le: ab_le, dclk: ab_clk, oe_n: ab_oe_n};
  assign ba_ctl = '{ce_n: ba_ce_n, le: ba_le, dclk: ba_clk, oe_n: ba_oe_n};

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .run    (run_q)
  );

  // A side in, B side out
  xcvr_dir_path #(.W(W)) u_ab (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .ctl      (ab_ctl),
    .d        (a_in),
    .q        (ab_word),
    .drive_en (ab_en)
  );

  // B side in, A side out
  xcvr_dir_path #(.W(W)) u_ba (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .ctl      (ba_ctl),
    .d        (b_in),
    .q        (ba_word),
    .drive_en (ba_en)
  );

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pin
      // open drain: only a zero is ever driven
      assign b_pull_low[gi] = ab_en & ~ab_word[gi];
      // three-state: value plus enable
      assign a_out[gi]      = ba_word[gi];
      assign a_oe[gi]       = ba_en;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic         ab_ce_n,
  input logic         ab_le,
  input logic         ab_oe_n,
  input logic         ba_ce_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_pull_low
);
  // R1: nothing drives while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_released_in_reset_r1: assert (a_oe == '0 && b_pull_low == '0);
    end
  end

  // R2: transparent path follows the A bus
  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && !ab_oe_n && run_q) |-> (b_pull_low == ~a_in));

  // R3: closing the latch keeps the word of the last open cycle
  p_latch_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ab_le) && !$past(ab_ce_n) && !ab_oe_n && run_q)
      |-> (b_pull_low == ~$past(a_in)));

  // R4: sampled rising direction clock loads the B bus word
  p_clock_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_ce_n && !ba_le && ba_clk && !$past(ba_clk))
      |=> (ba_le || a_out == $past(b_in)));

  // R5: storage enable high freezes the stored word
  p_inhibit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ce_n && !ab_le && !ab_oe_n && run_q)
      |=> (ab_le || ab_oe_n || $stable(b_pull_low)));

  // R6: disabled directions release every pin
  p_a_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (a_oe == '0));

  p_b_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (b_pull_low == '0));

  // R7: a pin pulled low reads low on the resolved bus
  p_wired_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_pull_low & b_in) == '0));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .ab_ce_n    (ab_ce_n),
  .ab_le      (ab_le),
  .ab_oe_n    (ab_oe_n),
  .ba_ce_n    (ba_ce_n),
  .ba_le      (ba_le),
  .ba_clk     (ba_clk),
  .ba_oe_n    (ba_oe_n),
  .a_in       (a_in),
  .b_in       (b_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_pull_low (b_pull_low)
);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;
  localparam int NV = 20;

  typedef struct packed {
    logic         dir;   // 0 = A-to-B, 1 = B-to-A
    logic         ce_n;
    logic         le;
    logic         dclk;
    logic         oe_n;
    logic [W-1:0] din;
    logic         en;    // expected drive state
    logic [W-1:0] word;  // expected output word
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'h2A5A5, 1'b1, 18'h2A5A5, 4'd2}, // R2 follow
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'h15A5A, 1'b1, 18'h15A5A, 4'd2}, // R2 follow
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 1'b1, 18'h15A5A, 4'd3}, // R3 close
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b1, 18'h15A5A, 4'd3}, // R3 hold
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h0F0F0, 1'b1, 18'h0F0F0, 4'd4}, // R4 edge
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h12345, 1'b1, 18'h0F0F0, 4'd4}, // R4 high
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h12345, 1'b1, 18'h0F0F0, 4'd4}, // R4 fall
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h3C3C3, 1'b1, 18'h0F0F0, 4'd5}, // R5 inhibit
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h3C3C3, 1'b1, 18'h0F0F0, 4'd5}, // R5 inhibit
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h2AAAA, 1'b1, 18'h2AAAA, 4'd2}, // R2 ce high
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h11111, 1'b1, 18'h0F0F0, 4'd5}, // R5 no load
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h11111, 1'b0, 18'h00000, 4'd6}, // R6 release
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 18'h00FFF, 1'b0, 18'h00000, 4'd6}, // R6 load off
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 1'b1, 18'h00FFF, 4'd6}, // R6 reappear
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h1C71C, 1'b1, 18'h1C71C, 4'd2}, // R2 b-to-a
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 1'b1, 18'h1C71C, 4'd3}, // R3 b-to-a
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h2DB6D, 1'b1, 18'h2DB6D, 4'd4}, // R4 b-to-a
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b1, 18'h2DB6D, 4'd5}, // R5 b-to-a
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h00001, 1'b1, 18'h2DB6D, 4'd5}, // R5 b-to-a
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 1'b0, 18'h00000, 4'd6}  // R6 b-to-a
  };

  logic         clk;
  logic         rst_n;
  logic         ab_ce_n, ab_le, ab_clk, ab_oe_n;
  logic         ba_ce_n, ba_le, ba_clk, ba_oe_n;
  logic [W-1:0] a_in;
  logic [W-1:0] a_out;
  logic [W-1:0] a_oe;
  logic [W-1:0] b_in;
  logic [W-1:0] b_pull_low;
  logic [W-1:0] b_ext_low;
  logic [W-1:0] b_bus;

  int n_chk;
  int n_bad;
  bit done;

  // pull-up bus: any agent pulling low wins
  assign b_bus = ~(b_pull_low | b_ext_low);
  assign b_in  = b_bus;

  bus_xcvr_reg #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_pull_low(b_pull_low)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ab_idle();
    ab_ce_n = 1'b1; ab_le = 1'b0; ab_clk = 1'b0; ab_oe_n = 1'b1;
  endtask

  task automatic ba_idle();
    ba_ce_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    ba_idle();
    ab_ce_n = 1'b1; ab_le = 1'b0; ab_clk = 1'b0; ab_oe_n = 1'b0;
    a_in = 18'h2468A; b_ext_low = '0;

    // R1: released during reset and for one edge after release
    repeat (2) @(negedge clk);
    chk("R1 reset b", b_pull_low, '0);
    chk("R1 reset a", a_oe, '0);
    rst_n = 1'b1;
    step();
    chk("R1 first edge", b_pull_low, '0);
    step();
    chk("R1 second edge, cleared word", b_pull_low, ONES);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (!VECS[i].dir) begin
        ba_idle();
        ab_ce_n = VECS[i].ce_n; ab_le = VECS[i].le;
        ab_clk = VECS[i].dclk;  ab_oe_n = VECS[i].oe_n;
        a_in = VECS[i].din; b_ext_low = '0;
      end else begin
        ab_idle();
        ba_ce_n = VECS[i].ce_n; ba_le = VECS[i].le;
        ba_clk = VECS[i].dclk;  ba_oe_n = VECS[i].oe_n;
        b_ext_low = ~VECS[i].din;
      end
      step();
      if (!VECS[i].dir) begin
        chk($sformatf("R%0d vec %0d b drive", VECS[i].req, i), b_pull_low,
            VECS[i].en ? ~VECS[i].word : '0);
      end else begin
        chk($sformatf("R%0d vec %0d a enable", VECS[i].req, i), a_oe,
            VECS[i].en ? ONES : '0);
        if (VECS[i].en)
          chk($sformatf("R9 vec %0d a value", i), a_out, VECS[i].word);
      end
    end

    // R8: other direction's controls leave A-to-B output alone
    ab_ce_n = 1'b1; ab_le = 1'b1; ab_clk = 1'b0; ab_oe_n = 1'b0;
    a_in = 18'h2BEEF; b_ext_low = '0;
    ba_ce_n = 1'b0; ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
    step();
    chk("R2 a-to-b transparent", b_pull_low, ~18'h2BEEF);
    ba_clk = 1'b1; ba_le = 1'b1; ba_oe_n = 1'b0;
    step();
    chk("R8 b drive unchanged", b_pull_low, ~18'h2BEEF);
    chk("R9 a enable", a_oe, ONES);
    chk("R9 a value from b bus", a_out, 18'h2BEEF);

    // R7: wired-OR with an external agent
    ba_idle();
    a_in = 18'h3FF00; b_ext_low = 18'h00F0F;
    step();
    chk("R7 pull pattern", b_pull_low, 18'h000FF);
    chk("R7 resolved bus", b_bus, 18'h3F000);

    // R1: reset mid-run clears a stored word
    b_ext_low = '0;
    ab_ce_n = 1'b0; ab_le = 1'b0; ab_clk = 1'b0; a_in = 18'h3FFFF;
    step();
    ab_clk = 1'b1;
    step();
    chk("R4 stored all ones", b_pull_low, '0);
    ab_ce_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1 async release", b_pull_low, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    step();
    chk("R1 word cleared", b_pull_low, ONES);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule